// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the hardware refill engine that runs when a translation cache misses. It takes the missing virtual address and the physical base of the top-level (master) table. It reads the master entry, then the secondary entry, through a single request/response memory port. It ends in one of two ways. The first is a one-cycle completion pulse that carries the frame number, the protection bits and the virtual page number, ready to be written into the translation cache. The second is a one-cycle fault pulse with a cause code.

The virtual address is split, from the top down, into a master index, a secondary index and a page offset. A master entry whose valid bit is clear means that no secondary table exists for that region. The walker stops there and faults without issuing the second read. The physical address reported on completion is the frame number placed above the unchanged page offset. Only one walk is in flight at any time, and only one memory read is outstanding at any time.

Top module: `pgwalk_two_level`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the walker is idle: walk_busy, mem_req_valid, walk_done and walk_fault are all low.
- R2: A walk accepted in idle issues its first read at address root_base + master_index * ENTRY_BYTES. The master index is va[VA_W-1 -: L1_W]. The request holds with an unchanged address until mem_req_ready is seen high.
- R3: Entry layout: bit 0 is the valid bit, bits [PROT_W:1] are the protection bits, and the top PFN_W bits are the frame number. A master entry with bit 0 clear ends the walk with walk_fault and fault_cause = 1, and no second read is issued.
- R4: A valid master entry leads to a second read at address {master_frame, OFF_W zeros} + secondary_index * ENTRY_BYTES. The secondary index is va[OFF_W+L2_W-1 -: L2_W].
- R5: A secondary entry with bit 0 clear ends the walk with walk_fault and fault_cause = 2.
- R6: A valid secondary entry ends the walk with walk_done. In that cycle: res_pfn is the entry's top PFN_W bits, res_prot is bits [PROT_W:1], res_vpn is va[VA_W-1:OFF_W], res_pa is {res_pfn, va[OFF_W-1:0]}, and fault_cause is 0.
- R7: walk_done and walk_fault are single-cycle pulses, never high together. walk_busy is high from the cycle after acceptance through the pulse cycle, and low in the cycle after the pulse.
- R8: walk_start while walk_busy is high is ignored: the walk in flight keeps its addresses and results.
- R9: mem_rsp_valid is ignored unless the walker is waiting for a read response.
- R10: After a request is accepted, mem_req_valid stays low until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Start a walk (taken only when idle) |
| walk_va | input | VA_W | Virtual address that missed |
| root_base | input | PA_W | Physical byte address of the master table |
| walk_busy | output | 1 | A walk is in flight |
| walk_done | output | 1 | One-cycle pulse: translation found |
| walk_fault | output | 1 | One-cycle pulse: walk faulted |
| fault_cause | output | 2 | 1 = secondary table absent, 2 = invalid leaf entry, 0 otherwise |
| res_vpn | output | L1_W+L2_W | Virtual page number of the walk |
| res_pfn | output | PFN_W | Frame number from the leaf entry |
| res_prot | output | PROT_W | Protection bits from the leaf entry |
| res_pa | output | PA_W | Frame number joined with the page offset |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W | Entry read from memory |

## Verification
The bench builds the walker with a 16-bit virtual and physical space: four master-index bits, four secondary-index bits, an 8-bit offset, 8-bit frame numbers and 4-byte entries. At that size, every master slot and every secondary slot of a real table can be populated. Absent tables, invalid leaves and the highest index values are all hit many times within a few hundred walks. The memory model varies its acceptance and response latency. It also throws stray responses and ignored start pulses between walks.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_READ_MASTER,
      WS_WAIT_MASTER,
      WS_READ_SECOND,
      WS_WAIT_SECOND,
      WS_DONE,
      WS_FAULT
   } walk_state_t;

   localparam logic [1:0] CAUSE_NONE     = 2'd0;
   localparam logic [1:0] CAUSE_NO_TABLE = 2'd1;
   localparam logic [1:0] CAUSE_BAD_LEAF = 2'd2;
endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
   parameter int PA_W        = 32,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);
   localparam bit POW2 = ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0);
   localparam int SH   = $clog2(ENTRY_BYTES);

   generate
      if (IDX_W > PA_W) begin : g_bad_idx
         $error("index wider than physical address");
      end
      if (POW2) begin : g_shift
         assign addr = base + (PA_W'(idx) << SH);
      end else begin : g_mult
         assign addr = base + PA_W'(idx) * PA_W'(ENTRY_BYTES);
      end
   endgenerate
endmodule

// File: rtl/pgwalk_pte_decode.sv
module pgwalk_pte_decode #(
   parameter int PTE_W  = 32,
   parameter int PFN_W  = 20,
   parameter int PROT_W = 4
) (
   input  logic [PTE_W-1:0]  pte,
   output logic              valid,
   output logic [PFN_W-1:0]  pfn,
   output logic [PROT_W-1:0] prot
);
   generate
      if (PTE_W <= PFN_W + PROT_W + 1) begin : g_bad_pte
         $error("entry too narrow for frame, protection and valid fields");
      end
   endgenerate

   logic unused_mid;

   assign valid      = pte[0];
   assign prot       = pte[PROT_W:1];
   assign pfn        = pte[PTE_W-1 -: PFN_W];
   assign unused_mid = ^pte[PTE_W-PFN_W-1:PROT_W+1];
endmodule

// File: rtl/pgwalk_two_level.sv
module pgwalk_two_level
   import pgwalk_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int L1_W        = 10,
   parameter int L2_W        = 10,
   parameter int PA_W        = 32,
   parameter int PFN_W       = 20,
   parameter int PTE_W       = 32,
   parameter int PROT_W      = 4,
   parameter int ENTRY_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   walk_start,
   input  logic [VA_W-1:0]        walk_va,
   input  logic [PA_W-1:0]        root_base,
   output logic                   walk_busy,
   output logic                   walk_done,
   output logic                   walk_fault,
   output logic [1:0]             fault_cause,
   output logic [L1_W+L2_W-1:0]   res_vpn,
   output logic [PFN_W-1:0]       res_pfn,
   output logic [PROT_W-1:0]      res_prot,
   output logic [PA_W-1:0]        res_pa,
   output logic                   mem_req_valid,
   output logic [PA_W-1:0]        mem_req_addr,
   input  logic                   mem_req_ready,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_W-1:0]       mem_rsp_data
);
   localparam int VPN_W = L1_W + L2_W;

   generate
      if (VA_W != L1_W + L2_W + OFF_W) begin : g_bad_va
         $error("virtual address split does not add up");
      end
      if (PA_W != PFN_W + OFF_W) begin : g_bad_pa
         $error("physical address must be frame plus offset");
      end
      if (ENTRY_BYTES < 1) begin : g_bad_entry
         $error("entry size must be positive");
      end
   endgenerate

   walk_state_t          state_q, state_d;
   logic [VA_W-1:0]      va_q;
   logic [PA_W-1:0]      root_q;
   logic [PA_W-1:0]      tbl_q;
   logic [PFN_W-1:0]     pfn_q;
   logic [PROT_W-1:0]    prot_q;
   logic [1:0]           cause_q;

   logic [L1_W-1:0]      l1_idx;
   logic [L2_W-1:0]      l2_idx;
   logic [PA_W-1:0]      master_addr, second_addr;
   logic                 ent_valid;
   logic [PFN_W-1:0]     ent_pfn;
   logic [PROT_W-1:0]    ent_prot;

   assign l1_idx = va_q[VA_W-1 -: L1_W];
   assign l2_idx = va_q[OFF_W+L2_W-1 -: L2_W];

   pgwalk_addr_gen #(.PA_W(PA_W), .IDX_W(L1_W), .ENTRY_BYTES(ENTRY_BYTES)) u_master_addr (
      .base (root_q),
      .idx  (l1_idx),
      .addr (master_addr)
   );

   pgwalk_addr_gen #(.PA_W(PA_W), .IDX_W(L2_W), .ENTRY_BYTES(ENTRY_BYTES)) u_second_addr (
      .base (tbl_q),
      .idx  (l2_idx),
      .addr (second_addr)
   );

   pgwalk_pte_decode #(.PTE_W(PTE_W), .PFN_W(PFN_W), .PROT_W(PROT_W)) u_decode (
      .pte   (mem_rsp_data),
      .valid (ent_valid),
      .pfn   (ent_pfn),
      .prot  (ent_prot)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE:        if (walk_start) state_d = WS_READ_MASTER;
         WS_READ_MASTER: if (mem_req_ready) state_d = WS_WAIT_MASTER;
         WS_WAIT_MASTER: if (mem_rsp_valid) state_d = ent_valid ? WS_READ_SECOND : WS_FAULT;
         WS_READ_SECOND: if (mem_req_ready) state_d = WS_WAIT_SECOND;
         WS_WAIT_SECOND: if (mem_rsp_valid) state_d = ent_valid ? WS_DONE : WS_FAULT;
         WS_DONE:        state_d = WS_IDLE;
         WS_FAULT:       state_d = WS_IDLE;
         default:        state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         va_q    <= '0;
         root_q  <= '0;
         tbl_q   <= '0;
         pfn_q   <= '0;
         prot_q  <= '0;
         cause_q <= CAUSE_NONE;
      end else begin
         state_q <= state_d;
         if (state_q == WS_IDLE && walk_start) begin
            va_q    <= walk_va;
            root_q  <= root_base;
            cause_q <= CAUSE_NONE;
         end
         if (state_q == WS_WAIT_MASTER && mem_rsp_valid) begin
            if (ent_valid) tbl_q <= {ent_pfn, {OFF_W{1'b0}}};
            else           cause_q <= CAUSE_NO_TABLE;
         end
         if (state_q == WS_WAIT_SECOND && mem_rsp_valid) begin
            if (ent_valid) begin
               pfn_q  <= ent_pfn;
               prot_q <= ent_prot;
            end else begin
               cause_q <= CAUSE_BAD_LEAF;
            end
         end
      end
   end

   assign mem_req_valid = (state_q == WS_READ_MASTER) || (state_q == WS_READ_SECOND);
   assign mem_req_addr  = (state_q == WS_READ_SECOND) ? second_addr : master_addr;
   assign walk_busy     = (state_q != WS_IDLE);
   assign walk_done     = (state_q == WS_DONE);
   assign walk_fault    = (state_q == WS_FAULT);
   assign fault_cause   = cause_q;
   assign res_vpn       = va_q[VA_W-1 -: VPN_W];
   assign res_pfn       = pfn_q;
   assign res_prot      = prot_q;
   assign res_pa        = {pfn_q, va_q[OFF_W-1:0]};

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R7
   pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_done || walk_fault) |=> (!walk_done && !walk_fault && !walk_busy));

   // R3
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_fault |-> (fault_cause != CAUSE_NONE));

   // R3
   no_second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WS_WAIT_MASTER && mem_rsp_valid && !ent_valid) |=> (walk_fault && !mem_req_valid));

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_busy && walk_start) |=> $stable(res_vpn));

   // R9
   stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_busy && !walk_start && mem_rsp_valid) |=> !walk_busy);
endmodule

// File: tb/pgwalk_two_level_tb.sv
module pgwalk_two_level_tb;
   localparam int VA_W = 16, OFF_W = 8, L1_W = 4, L2_W = 4, PA_W = 16;
   localparam int PFN_W = 8, PTE_W = 32, PROT_W = 4, EB = 4;
   localparam int ROOT = 16'h0040;
   localparam int S_IDLE = 0, S_RM = 1, S_WM = 2, S_RS = 3, S_WS = 4, S_DONE = 5, S_FAULT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic walk_start = 1'b0;
   logic [VA_W-1:0] walk_va = '0;
   logic [PA_W-1:0] root_base = '0;
   logic walk_busy, walk_done, walk_fault;
   logic [1:0] fault_cause;
   logic [L1_W+L2_W-1:0] res_vpn;
   logic [PFN_W-1:0] res_pfn;
   logic [PROT_W-1:0] res_prot;
   logic [PA_W-1:0] res_pa;
   logic mem_req_valid;
   logic [PA_W-1:0] mem_req_addr;
   logic mem_req_ready = 1'b0;
   logic mem_rsp_valid = 1'b0;
   logic [PTE_W-1:0] mem_rsp_data = '0;

   always #5 clk = ~clk;

   pgwalk_two_level #(
      .VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W), .PA_W(PA_W),
      .PFN_W(PFN_W), .PTE_W(PTE_W), .PROT_W(PROT_W), .ENTRY_BYTES(EB)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_va(walk_va),
      .root_base(root_base), .walk_busy(walk_busy), .walk_done(walk_done),
      .walk_fault(walk_fault), .fault_cause(fault_cause), .res_vpn(res_vpn),
      .res_pfn(res_pfn), .res_prot(res_prot), .res_pa(res_pa),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   logic [31:0] pmem [int];
   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   function automatic logic [31:0] mem_rd(int a);
      if (pmem.exists(a)) return pmem[a];
      return 32'h0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // reference model state
   int ms = S_IDLE;
   int m_va = 0, m_root = 0, m_tbl = 0, m_pfn = 0, m_prot = 0, m_cause = 0;
   int pend = -1;
   logic [31:0] pend_data = '0;
   int walks = 0, n_done = 0, n_nt = 0, n_bl = 0;

   function automatic int exp_addr();
      int l1 = (m_va >> 12) & 15;
      int l2 = (m_va >> 8) & 15;
      return (ms == S_RM) ? ((m_root + l1 * EB) & 16'hFFFF) : ((m_tbl + l2 * EB) & 16'hFFFF);
   endfunction

   initial begin
      // page tables
      for (int i = 0; i < 16; i++) begin
         if (i % 3 == 1) begin
            pmem[ROOT + i * 4] = {8'(16 + i), 24'h0};
         end else begin
            pmem[ROOT + i * 4] = {8'(16 + i), 23'h0, 1'b1};
            for (int j = 0; j < 16; j++) begin
               logic [7:0] pf = 8'(i * 16 + j) ^ 8'h5A;
               logic [3:0] pr = 4'(i + j);
               pmem[(16 + i) * 256 + j * 4] = {pf, 19'h0, pr, ((i + j) % 4 != 0) ? 1'b1 : 1'b0};
            end
         end
      end
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R1 busy in reset", 32'(walk_busy), 0);
         chk("R1 req in reset", 32'(mem_req_valid), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 32'(walk_busy), 0);
      chk("R1 req after reset", 32'(mem_req_valid), 0);
      chk("R1 done after reset", 32'(walk_done), 0);
      chk("R1 fault after reset", 32'(walk_fault), 0);

      for (int cyc = 0; cyc < 20000 && walks < 400; cyc++) begin
         // compare outputs against the model
         chk("R7 busy", 32'(walk_busy), 32'(ms != S_IDLE));
         chk("R10 req_valid", 32'(mem_req_valid), 32'(ms == S_RM || ms == S_RS));
         chk("R7 done pulse", 32'(walk_done), 32'(ms == S_DONE));
         chk("R7 fault pulse", 32'(walk_fault), 32'(ms == S_FAULT));
         if (ms == S_RM) chk("R2 master addr", 32'(mem_req_addr), 32'(exp_addr()));
         if (ms == S_RS) chk("R4 second addr", 32'(mem_req_addr), 32'(exp_addr()));
         if (ms == S_DONE || ms == S_FAULT)
            chk("R6 res_vpn", 32'(res_vpn), 32'((m_va >> 8) & 255));
         if (ms == S_DONE) begin
            chk("R6 res_pfn", 32'(res_pfn), 32'(m_pfn));
            chk("R6 res_prot", 32'(res_prot), 32'(m_prot));
            chk("R6 res_pa", 32'(res_pa), 32'((m_pfn << 8) | (m_va & 255)));
            chk("R6 cause zero", 32'(fault_cause), 0);
         end
         if (ms == S_FAULT)
            chk(m_cause == 1 ? "R3 cause" : "R5 cause", 32'(fault_cause), 32'(m_cause));

         // drive new inputs
         walk_start = 1'b0;
         if (ms == S_IDLE) begin
            if ($urandom_range(1, 0) == 1) begin
               walk_start = 1'b1;
               walk_va    = 16'($urandom);
               if (walks % 20 == 0) walk_va = 16'hFFFF;
               root_base  = 16'(ROOT);
            end
         end else if ($urandom_range(3, 0) == 0) begin
            walk_start = 1'b1;           // R8: ignored while busy
            walk_va    = 16'($urandom);
            root_base  = 16'($urandom);
         end
         mem_req_ready = ($urandom_range(2, 0) != 0);
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = 32'($urandom);
         if (pend == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pend_data;
            pend = -1;
         end else if (pend > 0) begin
            pend--;
         end else if (ms != S_WM && ms != S_WS && $urandom_range(3, 0) == 0) begin
            mem_rsp_valid = 1'b1;        // R9: stray response
            mem_rsp_data  = 32'hFFFF_FFFF;
         end

         // advance the model across the coming edge
         case (ms)
            S_IDLE: if (walk_start) begin
               m_va = int'(walk_va); m_root = int'(root_base); ms = S_RM;
            end
            S_RM: if (mem_req_ready) begin
               pend_data = mem_rd(exp_addr()); pend = $urandom_range(2, 0); ms = S_WM;
            end
            S_WM: if (mem_rsp_valid) begin
               if (mem_rsp_data[0]) begin
                  m_tbl = int'(mem_rsp_data[31:24]) << 8; ms = S_RS;
               end else begin
                  m_cause = 1; ms = S_FAULT; n_nt++;
               end
            end
            S_RS: if (mem_req_ready) begin
               pend_data = mem_rd(exp_addr()); pend = $urandom_range(2, 0); ms = S_WS;
            end
            S_WS: if (mem_rsp_valid) begin
               if (mem_rsp_data[0]) begin
                  m_pfn = int'(mem_rsp_data[31:24]); m_prot = int'(mem_rsp_data[4:1]);
                  ms = S_DONE; n_done++;
               end else begin
                  m_cause = 2; ms = S_FAULT; n_bl++;
               end
            end
            default: begin ms = S_IDLE; walks++; end
         endcase
         @(negedge clk);
      end
      chk("R3 absent-table walks seen", 32'(n_nt > 0), 1);
      chk("R5 bad-leaf walks seen", 32'(n_bl > 0), 1);
      chk("R6 completed walks seen", 32'(n_done > 0), 1);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL R7 watchdog expired: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule